// File: doc/BRIEF.md
# Overcurrent Trip Latch with Timed Release

This block guards a three-phase bridge against overcurrent. A digitised comparator input first passes a noise filter. Once the filtered input is high, it sets a trip latch in which set always wins over clear. While the trip is held, all six gate request lines are masked to zero. The latch only clears when a fault-clear timer expires. That timer replaces the charging of an external capacitor. Its length is a programmable number of units, each a fixed number of clock cycles, so doubling the setting doubles the hold time.

An active-low fault flag reports the trip after a fixed latency of clock cycles. The same flag also reports an undervoltage on the control supply. A global enable input and the undervoltage input each block the gate outputs directly. Neither of them changes the state of the trip latch.

When the clear timer expires while the filtered overcurrent input is still high, the set input wins. The trip stays asserted and the timer starts a fresh interval. The block releases only at the first expiry that finds the filtered input low.

Top module: `oc_trip_guard`

## Requirements
- R1: While `trip_o` is 1, all bits of `gate_out` are 0. While `trip_o`, `uv_in` are 0 and `en_in` is 1, `gate_out` equals `gate_in`.
- R2: `oc_in` must be sampled high on FILT_CYC consecutive rising edges to set the trip. If the first of those edges is edge k, `trip_o` is 1 after edge k+FILT_CYC. A pulse sampled on fewer than FILT_CYC edges leaves `trip_o` at 0.
- R3: When the filtered input is low at expiry, `trip_o` stays 1 for exactly L cycles after it rises and is 0 after the L-th edge. L = max(`clr_units`,1) × UNIT_CYC. The trip never clears before that expiry.
- R4: The hold time scales linearly with `clr_units`. A setting of 0 behaves as 1 unit.
- R5: Set dominates clear. If the filtered input is still high at an expiry, `trip_o` stays 1 and a new interval of L cycles begins.
- R6: `fault_n_o` goes to 0 exactly FLAG_DLY cycles after `trip_o` rises. It returns to 1 exactly FLAG_DLY cycles after `trip_o` falls, unless undervoltage is present.
- R7: If `uv_in` is first sampled high at edge u, `fault_n_o` is 0 after edge u+FLAG_DLY−1. While `uv_in` is 1, `gate_out` is 0. Undervoltage never sets `trip_o`.
- R8: `en_in` = 0 forces `gate_out` to 0. It does not clear a pending trip and does not move the release cycle.
- R9: During reset (`rst_n` = 0), `trip_o` is 0 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_in | input | 1 | Digitised overcurrent comparator, 1 = overcurrent |
| en_in | input | 1 | Global enable, 0 blocks all gates |
| uv_in | input | 1 | Control-supply undervoltage, 1 = low supply |
| clr_units | input | UNIT_W | Fault-clear interval in units of UNIT_CYC cycles |
| gate_in | input | N_GATE | Gate requests from the modulator |
| gate_out | output | N_GATE | Masked gate commands |
| trip_o | output | 1 | Trip latch state |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The bench sends a pulse one sample too short for the filter. A filter that is off by one would trip on it. It also holds the comparator input high across the first expiry. A latch where clear wins would release there and re-enable the gates, even though overcurrent is still present. It then checks the exact release cycle at settings of 0, 2 and 3 units. A wrong scaling, or no clamp of the zero setting, would move the release cycle or release at once. Finally, it drops the enable during a trip and raises undervoltage on its own. A design that let the enable clear the latch, or that let undervoltage set it, would show a wrong `trip_o` or flag timing.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;

  // A zero interval setting is treated as one unit so the trip is never released at once.
  function automatic logic [31:0] clamp_units(input logic [31:0] units);
    return (units == 32'd0) ? 32'd1 : units;
  endfunction

endpackage

// File: rtl/oc_noise_filter.sv
module oc_noise_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (!raw_i)                        run_d = '0;
    else if (run_q != CW'(FILT_CYC))   run_d = run_q + 1'b1;
    else                               run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign filt_o = (run_q == CW'(FILT_CYC));
endmodule

// File: rtl/oc_clear_timer.sv
module oc_clear_timer #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             expire_o
);
  logic [LIM_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  assign expire_o = run_i && (tmr_q == LIM_W'(lim_i - 1'b1));

  always_comb begin
    tmr_en = run_i || (tmr_q != '0);
    if (!run_i || expire_o) tmr_d = '0;
    else                    tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/oc_trip_latch.sv
module oc_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic trip_o
);
  logic trip_q, trip_d;

  // set wins over clear
  always_comb trip_d = set_i | (trip_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/oc_flag_delay.sv
module oc_flag_delay #(
  parameter int FLAG_DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  output logic flag_n_o
);
  logic [FLAG_DLY-1:0] pipe_q, pipe_d;

  generate
    if (FLAG_DLY == 1) begin : g_single
      always_comb pipe_d = src_i;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[FLAG_DLY-2:0], src_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign flag_n_o = ~pipe_q[FLAG_DLY-1];
endmodule

// File: rtl/oc_trip_guard.sv
module oc_trip_guard
  import oc_trip_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int UNIT_CYC = 8,
  parameter int UNIT_W   = 4,
  parameter int FLAG_DLY = 5,
  parameter int N_GATE   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_in,
  input  logic              en_in,
  input  logic              uv_in,
  input  logic [UNIT_W-1:0] clr_units,
  input  logic [N_GATE-1:0] gate_in,
  output logic [N_GATE-1:0] gate_out,
  output logic              trip_o,
  output logic              fault_n_o
);
  localparam int LIM_W = UNIT_W + $clog2(UNIT_CYC) + 1;

  logic             filt_w;
  logic             expire_w;
  logic             trip_w;
  logic             pass_w;
  logic [LIM_W-1:0] lim_w;

  always_comb lim_w = LIM_W'(clamp_units(32'(clr_units)) * UNIT_CYC);

  oc_noise_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(oc_in), .filt_o(filt_w)
  );

  oc_trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(filt_w), .clr_i(expire_w), .trip_o(trip_w)
  );

  oc_clear_timer #(.LIM_W(LIM_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(trip_w), .lim_i(lim_w), .expire_o(expire_w)
  );

  oc_flag_delay #(.FLAG_DLY(FLAG_DLY)) u_flag (
    .clk(clk), .rst_n(rst_n), .src_i(trip_w | uv_in), .flag_n_o(fault_n_o)
  );

  assign pass_w = en_in & ~trip_w & ~uv_in;
  assign trip_o = trip_w;

  generate
    for (genvar g = 0; g < N_GATE; g++) begin : g_mask
      assign gate_out[g] = gate_in[g] & pass_w;
    end
  endgenerate
endmodule

// File: rtl/oc_trip_guard_chk.sv
module oc_trip_guard_chk #(
  parameter int N_GATE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              filt,
  input logic              expire,
  input logic              trip,
  input logic              en,
  input logic              uv,
  input logic [N_GATE-1:0] gate_out
);
  assert_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (gate_out == '0));

  assert_rise_needs_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(filt));

  assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !expire) |=> trip);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    filt |=> trip);

  assert_uv_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (gate_out == '0));

  assert_en_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_out == '0));
endmodule

bind oc_trip_guard oc_trip_guard_chk #(.N_GATE(N_GATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt(filt_w), .expire(expire_w), .trip(trip_w),
  .en(en_in), .uv(uv_in), .gate_out(gate_out)
);

// File: tb/oc_trip_guard_tb.sv
module oc_trip_guard_tb;
  localparam int FILT = 4;
  localparam int UNIT = 8;
  localparam int UW   = 4;
  localparam int DLY  = 5;
  localparam int NG   = 6;
  localparam logic [NG-1:0] GI = 6'h2D;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          oc_in, en_in, uv_in;
  logic [UW-1:0] clr_units;
  logic [NG-1:0] gate_in, gate_out;
  logic          trip_o, fault_n_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  typedef struct {
    int         cyc;
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  oc_trip_guard #(.FILT_CYC(FILT), .UNIT_CYC(UNIT), .UNIT_W(UW),
                  .FLAG_DLY(DLY), .N_GATE(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_in), .en_in(en_in), .uv_in(uv_in),
    .clr_units(clr_units), .gate_in(gate_in), .gate_out(gate_out),
    .trip_o(trip_o), .fault_n_o(fault_n_o)
  );

  // driver side: queue an expected {trip, fault_n, gates} after edge c
  function automatic void expect_at(int c, logic t, logic f, logic [NG-1:0] g, string tag);
    exp_t it;
    int   pos;
    it.cyc = c; it.v = {t, f, g}; it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > c) begin pos = i; break; end
    end
    q.insert(pos, it);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s cyc %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // monitor: pop and compare 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #3;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t it;
        it = q.pop_front();
        chk(it.tag, {trip_o, fault_n_o, gate_out}, it.v);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    idle(DLY + 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, s;
    rst_n = 1'b0; oc_in = 1'b0; en_in = 1'b1; uv_in = 1'b0;
    clr_units = 4'd2; gate_in = GI;
    idle(3);
    chk("R9 trip in reset", {7'd0, trip_o}, 8'd0);
    chk("R9 fault_n in reset", {7'd0, fault_n_o}, 8'd1);
    chk("R1 pass-through", {2'd0, gate_out}, {2'd0, GI});
    rst_n = 1'b1;
    idle(3);

    // R2: pulse one sample shorter than the filter
    n = cyc; oc_in = 1'b1;
    expect_at(n + 4, 0, 1, GI, "R2 short pulse");
    expect_at(n + 5, 0, 1, GI, "R2 short pulse");
    expect_at(n + 6, 0, 1, GI, "R2 short pulse");
    idle(FILT - 1); oc_in = 1'b0;
    drain();

    // R1 R3 R6: minimal trip, 2 units = 16 cycles
    n = cyc; s = n + FILT + 1; oc_in = 1'b1;
    expect_at(n + 4, 0, 1, GI, "R2 not yet set");
    expect_at(s, 1, 1, 0, "R1 trip masks gates");
    expect_at(s + DLY - 1, 1, 1, 0, "R6 flag latency");
    expect_at(s + DLY, 1, 0, 0, "R6 flag low");
    expect_at(s + 15, 1, 0, 0, "R3 still held");
    expect_at(s + 16, 0, 0, GI, "R3 release cycle");
    expect_at(s + 16 + DLY - 1, 0, 0, GI, "R6 flag hold");
    expect_at(s + 16 + DLY, 0, 1, GI, "R6 flag release");
    idle(FILT); oc_in = 1'b0;
    drain();

    // R5: overcurrent still present at first expiry
    n = cyc; s = n + FILT + 1; oc_in = 1'b1;
    expect_at(s + 16, 1, 0, 0, "R5 set wins at expiry");
    expect_at(s + 31, 1, 0, 0, "R5 restarted interval");
    expect_at(s + 32, 0, 0, GI, "R5 release after restart");
    idle(25); oc_in = 1'b0;
    drain();

    // R4: zero setting acts as one unit
    clr_units = 4'd0;
    n = cyc; s = n + FILT + 1; oc_in = 1'b1;
    expect_at(s + 7, 1, 0, 0, "R4 zero setting held");
    expect_at(s + 8, 0, 0, GI, "R4 zero setting release");
    idle(FILT); oc_in = 1'b0;
    drain();

    // R4: three units = 24 cycles
    clr_units = 4'd3;
    n = cyc; s = n + FILT + 1; oc_in = 1'b1;
    expect_at(s + 23, 1, 0, 0, "R4 three units held");
    expect_at(s + 24, 0, 0, GI, "R4 three units release");
    idle(FILT); oc_in = 1'b0;
    drain();

    // R8: enable dropped during a trip
    clr_units = 4'd2;
    n = cyc; s = n + FILT + 1; oc_in = 1'b1;
    expect_at(s + 15, 1, 0, 0, "R8 trip kept with enable low");
    expect_at(s + 16, 0, 0, 0, "R8 release on time, gates blocked");
    expect_at(n + 25, 0, 0, GI, "R8 gates back with enable");
    idle(FILT); oc_in = 1'b0;
    idle(6); en_in = 1'b0;
    idle(n + 24 - cyc); en_in = 1'b1;
    drain();

    // R7: undervoltage alone
    n = cyc; uv_in = 1'b1;
    expect_at(n + 1, 0, 1, 0, "R7 gates blocked, no trip");
    expect_at(n + DLY - 1, 0, 1, 0, "R7 flag latency");
    expect_at(n + DLY, 0, 0, 0, "R7 flag low");
    expect_at(n + 8 + DLY - 1, 0, 0, GI, "R7 flag hold");
    expect_at(n + 8 + DLY, 0, 1, GI, "R7 flag release");
    idle(8); uv_in = 1'b0;
    drain();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule